// File: doc/BRIEF.md
# Time-Scheduled Event Output Unit

This block lets software queue actions that happen at an exact timer value. Software writes a command byte and then a 16-bit time stamp. The pair lands in a single holding register. From there it moves into a small file of command slots. A scanner visits one slot per clock and compares the slot's stored time with whichever of two free-running timer values the command selected. When the values are equal, the command's action runs. An action can drive one of six output pins high or low, set one of four software-timer flags, pulse a conversion-start strobe, or pulse a reset request for the second timer.

An entry marked as locked stays in its slot after it fires, and it fires again each time the timer comes back to its stored value. This is how repeating waveforms, such as several pulse-width outputs, are produced without software refilling the slots. Entries that are not locked free their slot once they have run. A dedicated command code empties the whole file at once, locked entries included. Two status outputs tell software when another command may be written. The timers themselves are supplied from outside the block.

Top module: `timed_output_unit`

## Requirements
- R1: The scanner visits one slot per clock in ascending order and wraps after slot 7, so a full pass takes 8 clocks. An entry matches when it is valid and its stored time equals its selected timer during its own slot. The action is visible on the outputs one clock after that slot, so a match is seen within 8 clocks of the timer reaching the stored time.
- R2: The command byte is laid out as follows:
  - bit 7: lock
  - bit 6: timer select
  - bit 5: interrupt enable
  - bit 4: pin level
  - bits 3:0: action code. Codes 0 to 5 drive pin 0 to 5. Codes 8 to 11 set software flag 0 to 3. Code 12 pulses conversion start. Code 13 pulses the timer-2 reset request. Code 15 clears the file. Codes 6, 7 and 14 perform no action.
- R3: A time write copies the most recently written command byte and the time word into the holding register. On the next clock the holding register moves into the lowest-numbered free slot.
- R4: While the holding register is full and no slot is free, its contents wait unchanged. Any time write made while it is full is ignored.
- R5: `hold_empty` is 1 when the holding register is empty. `hold_ready` is 1 when the holding register is empty and at least one slot is free.
- R6: Timer select 0 compares the entry against `timer1`. Timer select 1 compares it against `timer2`. The timer that was not selected never triggers the entry.
- R7: A pin action drives the addressed pin to the level bit and holds it there until another action on that pin. If interrupt enable is set, `pin_irq` pulses for one clock.
- R8: A software-flag action sets the addressed flag, and the flag stays set until the matching `swt_clr` bit is asserted. If interrupt enable is set, `swt_irq` pulses for one clock.
- R9: Code 12 makes `conv_start` high for exactly one clock. Code 13 makes `t2_reset` high for exactly one clock. These strobes never appear without a match.
- R10: A locked entry stays in its slot after firing and fires again at every later match. An unlocked entry frees its slot after firing.
- R11: A command write with code 15 empties every slot on the next clock, locked entries included. It leaves the holding register and the staged command byte unchanged.
- R12: After reset, the pins, flags and strobes are 0, all slots are free, and `hold_empty` and `hold_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one scan slot per cycle |
| rst_n | input | 1 | Active-low reset |
| timer1 | input | 16 | First reference timer value |
| timer2 | input | 16 | Second reference timer value |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_byte | input | 8 | Command byte |
| time_wr | input | 1 | Time word write strobe; loads the holding register |
| time_word | input | 16 | Time stamp for the staged command |
| swt_clr | input | 4 | Per-flag clear for the software flags |
| pins | output | 6 | Scheduled output pins |
| swt_flags | output | 4 | Software-timer flags |
| conv_start | output | 1 | One-clock conversion start strobe |
| t2_reset | output | 1 | One-clock timer-2 reset request |
| pin_irq | output | 1 | Pin-action interrupt pulse |
| swt_irq | output | 1 | Software-flag interrupt pulse |
| hold_empty | output | 1 | Holding register is empty |
| hold_ready | output | 1 | Holding register is empty and a slot is free |

## Verification
The bench first sweeps every pin code with a set command and then with a clear command, giving each a distinct time. At each step it checks the full pin vector and counts interrupt pulses. This exposes decode errors, a wrong level, and a wrong interrupt-enable gate. Each software flag and both strobes are swept in the same way, and the pulse counts separate one-clock strobes from stuck ones. A locked entry and an unlocked entry on the same pin, both referenced to timer 2, show that the unselected timer is ignored and that only the locked entry refires. Filling all eight slots and then queuing two more commands shows that a stalled holding register keeps its first command and drops the second. It also shows that a freed slot takes the waiting command, and that the clear command removes a locked entry.

// File: rtl/tou_pkg.sv
package tou_pkg;

    localparam int CODE_W = 4;

    typedef struct packed {
        logic              lock;
        logic              use_t2;
        logic              irq_en;
        logic              level;
        logic [CODE_W-1:0] code;
    } cmd_t;

    localparam logic [CODE_W-1:0] CODE_SWT_BASE = 4'd8;
    localparam logic [CODE_W-1:0] CODE_CONV     = 4'd12;
    localparam logic [CODE_W-1:0] CODE_T2RST    = 4'd13;
    localparam logic [CODE_W-1:0] CODE_CLEAR    = 4'd15;

endpackage

// File: rtl/tou_intake.sv
module tou_intake import tou_pkg::*; #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_wr,
    input  logic [7:0]    cmd_byte,
    input  logic          time_wr,
    input  logic [TW-1:0] time_word,
    input  logic          take_i,
    output logic          hold_full_o,
    output cmd_t          hold_cmd_o,
    output logic [TW-1:0] hold_time_o,
    output logic          clear_o
);

    typedef struct packed {
        cmd_t          staged;
        logic          full;
        cmd_t          hcmd;
        logic [TW-1:0] htime;
    } intake_st_t;

    intake_st_t st_d, st_q;
    cmd_t       wr_cmd;

    always_comb begin
        wr_cmd  = cmd_t'(cmd_byte);
        clear_o = cmd_wr && (wr_cmd.code == CODE_CLEAR);
        st_d    = st_q;
        if (cmd_wr && !clear_o) begin
            st_d.staged = wr_cmd;
        end
        if (take_i) begin
            st_d.full = 1'b0;
        end
        // a write that arrives while the holder is occupied is dropped
        if (time_wr && !st_q.full) begin
            st_d.full  = 1'b1;
            st_d.hcmd  = st_q.staged;
            st_d.htime = time_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_full_o = st_q.full;
    assign hold_cmd_o  = st_q.hcmd;
    assign hold_time_o = st_q.htime;

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.full && time_wr) |=> (st_q.full && st_q.htime == $past(time_word)));

    p_stall_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.full && !take_i) |=> (st_q.full && $stable(st_q.htime) && $stable(st_q.hcmd)));

endmodule

// File: rtl/tou_cam_file.sv
module tou_cam_file import tou_pkg::*; #(
    parameter int SLOTS = 8,
    parameter int TW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] timer1,
    input  logic [TW-1:0] timer2,
    input  logic          hold_full_i,
    input  cmd_t          hold_cmd_i,
    input  logic [TW-1:0] hold_time_i,
    input  logic          clear_i,
    output logic          take_o,
    output logic          any_free_o,
    output logic          fire_o,
    output cmd_t          fire_cmd_o
);

    localparam int SLOT_W = $clog2(SLOTS);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    typedef struct packed {
        logic [SLOT_W-1:0]          scan;
        logic [SLOTS-1:0]           valid;
        cmd_t [SLOTS-1:0]           cmd;
        logic [SLOTS-1:0][TW-1:0]   stamp;
    } cam_st_t;

    cam_st_t           st_d, st_q;
    logic [SLOT_W-1:0] ins_idx;
    logic [TW-1:0]     ref_time;
    cmd_t              cur_cmd;

    always_comb begin
        ins_idx    = '0;
        any_free_o = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!st_q.valid[i]) begin
                ins_idx    = SLOT_W'(i);
                any_free_o = 1'b1;
            end
        end

        cur_cmd  = st_q.cmd[st_q.scan];
        ref_time = cur_cmd.use_t2 ? timer2 : timer1;
        fire_o   = st_q.valid[st_q.scan] && (st_q.stamp[st_q.scan] == ref_time) && !clear_i;
        take_o   = hold_full_i && any_free_o && !clear_i;

        st_d      = st_q;
        st_d.scan = (st_q.scan == LAST) ? '0 : st_q.scan + 1'b1;
        if (fire_o && !cur_cmd.lock) begin
            st_d.valid[st_q.scan] = 1'b0;
        end
        if (take_o) begin
            st_d.valid[ins_idx] = 1'b1;
            st_d.cmd[ins_idx]   = hold_cmd_i;
            st_d.stamp[ins_idx] = hold_time_i;
        end
        if (clear_i) begin
            st_d.valid = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_cmd_o = cur_cmd;

    p_scan_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.scan == LAST) |=> (st_q.scan == '0));

    p_locked_stays_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && cur_cmd.lock) |=> st_q.valid[$past(st_q.scan)]);

    p_unlocked_freed_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !cur_cmd.lock) |=> !st_q.valid[$past(st_q.scan)]);

    p_clear_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (st_q.valid == '0));

endmodule

// File: rtl/tou_actions.sv
module tou_actions import tou_pkg::*; #(
    parameter int NPINS = 6,
    parameter int NSWT  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              level_i,
    input  logic              irq_en_i,
    input  logic [NSWT-1:0]   swt_clr,
    output logic [NPINS-1:0]  pins_o,
    output logic [NSWT-1:0]   flags_o,
    output logic              conv_o,
    output logic              t2rst_o,
    output logic              pin_irq_o,
    output logic              swt_irq_o
);

    typedef struct packed {
        logic [NPINS-1:0] pins;
        logic [NSWT-1:0]  flags;
        logic             conv;
        logic             t2rst;
        logic             pin_irq;
        logic             swt_irq;
    } act_st_t;

    act_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.flags   = st_q.flags & ~swt_clr;
        st_d.conv    = 1'b0;
        st_d.t2rst   = 1'b0;
        st_d.pin_irq = 1'b0;
        st_d.swt_irq = 1'b0;
        if (fire_i) begin
            for (int k = 0; k < NPINS; k++) begin
                if (code_i == CODE_W'(k)) begin
                    st_d.pins[k] = level_i;
                    st_d.pin_irq = irq_en_i;
                end
            end
            for (int k = 0; k < NSWT; k++) begin
                if (code_i == CODE_SWT_BASE + CODE_W'(k)) begin
                    st_d.flags[k] = 1'b1;
                    st_d.swt_irq  = irq_en_i;
                end
            end
            st_d.conv  = (code_i == CODE_CONV);
            st_d.t2rst = (code_i == CODE_T2RST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pins_o    = st_q.pins;
    assign flags_o   = st_q.flags;
    assign conv_o    = st_q.conv;
    assign t2rst_o   = st_q.t2rst;
    assign pin_irq_o = st_q.pin_irq;
    assign swt_irq_o = st_q.swt_irq;

    p_strobe_needs_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> !(st_q.conv || st_q.t2rst || st_q.pin_irq || st_q.swt_irq));

    p_pins_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> $stable(st_q.pins));

endmodule

// File: rtl/timed_output_unit.sv
module timed_output_unit import tou_pkg::*; #(
    parameter int SLOTS = 8,
    parameter int TW    = 16,
    parameter int NPINS = 6,
    parameter int NSWT  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TW-1:0]    timer1,
    input  logic [TW-1:0]    timer2,
    input  logic             cmd_wr,
    input  logic [7:0]       cmd_byte,
    input  logic             time_wr,
    input  logic [TW-1:0]    time_word,
    input  logic [NSWT-1:0]  swt_clr,
    output logic [NPINS-1:0] pins,
    output logic [NSWT-1:0]  swt_flags,
    output logic             conv_start,
    output logic             t2_reset,
    output logic             pin_irq,
    output logic             swt_irq,
    output logic             hold_empty,
    output logic             hold_ready
);

    logic          hold_full, take, clear, any_free, fire;
    cmd_t          hold_cmd, fire_cmd;
    logic [TW-1:0] hold_time;

    tou_intake #(.TW(TW)) u_intake (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_wr      (cmd_wr),
        .cmd_byte    (cmd_byte),
        .time_wr     (time_wr),
        .time_word   (time_word),
        .take_i      (take),
        .hold_full_o (hold_full),
        .hold_cmd_o  (hold_cmd),
        .hold_time_o (hold_time),
        .clear_o     (clear)
    );

    tou_cam_file #(.SLOTS(SLOTS), .TW(TW)) u_cam (
        .clk         (clk),
        .rst_n       (rst_n),
        .timer1      (timer1),
        .timer2      (timer2),
        .hold_full_i (hold_full),
        .hold_cmd_i  (hold_cmd),
        .hold_time_i (hold_time),
        .clear_i     (clear),
        .take_o      (take),
        .any_free_o  (any_free),
        .fire_o      (fire),
        .fire_cmd_o  (fire_cmd)
    );

    tou_actions #(.NPINS(NPINS), .NSWT(NSWT)) u_act (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire_i    (fire),
        .code_i    (fire_cmd.code),
        .level_i   (fire_cmd.level),
        .irq_en_i  (fire_cmd.irq_en),
        .swt_clr   (swt_clr),
        .pins_o    (pins),
        .flags_o   (swt_flags),
        .conv_o    (conv_start),
        .t2rst_o   (t2_reset),
        .pin_irq_o (pin_irq),
        .swt_irq_o (swt_irq)
    );

    assign hold_empty = !hold_full;
    assign hold_ready = !hold_full && any_free;

    p_ready_implies_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ready |-> hold_empty);

endmodule

// File: tb/timed_output_unit_test.sv
module timed_output_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer1 = 16'hFFFF;
    logic [15:0] timer2 = 16'hFFFF;
    logic        cmd_wr = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic        time_wr = 1'b0;
    logic [15:0] time_word = 16'h0000;
    logic [3:0]  swt_clr = 4'h0;
    logic [5:0]  pins;
    logic [3:0]  swt_flags;
    logic        conv_start, t2_reset, pin_irq, swt_irq, hold_empty, hold_ready;

    int n_checks = 0;
    int n_errors = 0;
    int n_pirq = 0, n_sirq = 0, n_conv = 0, n_t2r = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    timed_output_unit uut (
        .clk(clk), .rst_n(rst_n), .timer1(timer1), .timer2(timer2),
        .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .time_wr(time_wr),
        .time_word(time_word), .swt_clr(swt_clr), .pins(pins),
        .swt_flags(swt_flags), .conv_start(conv_start), .t2_reset(t2_reset),
        .pin_irq(pin_irq), .swt_irq(swt_irq), .hold_empty(hold_empty),
        .hold_ready(hold_ready)
    );

    always @(posedge clk) begin
        if (pin_irq)    n_pirq++;
        if (swt_irq)    n_sirq++;
        if (conv_start) n_conv++;
        if (t2_reset)   n_t2r++;
    end

    function automatic logic [7:0] mk(input bit lk, input bit t2, input bit irq,
                                      input bit lvl, input int code);
        return {lk, t2, irq, lvl, 4'(code)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_time_only(input logic [15:0] t);
        @(negedge clk); time_wr = 1'b1; time_word = t;
        @(negedge clk); time_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic put(input logic [7:0] c, input logic [15:0] t);
        @(negedge clk); cmd_wr = 1'b1; cmd_byte = c;
        @(negedge clk); cmd_wr = 1'b0;
        write_time_only(t);
    endtask

    task automatic clear_file();
        @(negedge clk); cmd_wr = 1'b1; cmd_byte = 8'h0F;
        @(negedge clk); cmd_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(input logic [15:0] a, input logic [15:0] b, input int n);
        @(negedge clk); timer1 = a; timer2 = b;
        repeat (n) @(negedge clk);
        timer1 = 16'hFFFF; timer2 = 16'hFFFF;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [5:0] exp_pins;
        int base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 pins", 32'(pins), 0);
        chk("R12 flags", 32'(swt_flags), 0);
        chk("R12 strobes", {30'd0, conv_start, t2_reset}, 0);
        chk("R12 hold_empty", 32'(hold_empty), 1);
        chk("R12 hold_ready", 32'(hold_ready), 1);

        // R2 R7 pin set sweep with interrupt enabled
        for (int k = 0; k < 6; k++) put(mk(0, 0, 1, 1, k), 16'(1000 + k));
        chk("R3 holder drained", 32'(hold_empty), 1);
        exp_pins = '0;
        for (int k = 0; k < 6; k++) begin
            base = n_pirq;
            run(16'(1000 + k), 16'h0, 10);
            exp_pins[k] = 1'b1;
            chk("R7 pin set sweep", 32'(pins), 32'(exp_pins));
            chk("R7 irq pulse count", 32'(n_pirq - base), 1);
        end
        // R7 pin clear sweep with interrupt disabled
        for (int k = 0; k < 6; k++) put(mk(0, 0, 0, 0, k), 16'(2000 + k));
        for (int k = 0; k < 6; k++) begin
            base = n_pirq;
            run(16'(2000 + k), 16'h0, 10);
            exp_pins[k] = 1'b0;
            chk("R7 pin clear sweep", 32'(pins), 32'(exp_pins));
            chk("R7 irq gated off", 32'(n_pirq - base), 0);
        end

        // R8 software flags
        clear_file();
        for (int j = 0; j < 4; j++) put(mk(0, 0, 1, 0, 8 + j), 16'(3000 + j));
        for (int j = 0; j < 4; j++) begin
            base = n_sirq;
            run(16'(3000 + j), 16'h0, 10);
            chk("R8 flag set", 32'(swt_flags), 32'((1 << (j + 1)) - 1));
            chk("R8 swt irq count", 32'(n_sirq - base), 1);
        end
        chk("R8 no pin irq from flags", 32'(pins), 0);
        @(negedge clk); swt_clr = 4'b0101;
        @(negedge clk); swt_clr = 4'b0000;
        chk("R8 partial clear", 32'(swt_flags), 32'b1010);

        // R9 strobes
        base = n_conv;
        put(mk(0, 0, 0, 0, 12), 16'd4000);
        put(mk(0, 0, 0, 0, 13), 16'd4001);
        chk("R9 no strobe before match", 32'(n_conv - base), 0);
        base = n_t2r;
        run(16'd4000, 16'h0, 10);
        chk("R9 conv one clock", 32'(n_conv), 1);
        chk("R9 t2 reset not yet", 32'(n_t2r - base), 0);
        run(16'd4001, 16'h0, 10);
        chk("R9 t2 reset one clock", 32'(n_t2r - base), 1);
        chk("R9 conv unchanged", 32'(n_conv), 1);

        // R6 R10 locked entry on timer2
        clear_file();
        put(mk(1, 1, 0, 1, 0), 16'd200);
        put(mk(0, 1, 0, 0, 0), 16'd300);
        run(16'd200, 16'd0, 10);
        chk("R6 timer1 ignored", 32'(pins[0]), 0);
        run(16'd0, 16'd200, 10);
        chk("R6 timer2 match", 32'(pins[0]), 1);
        run(16'd0, 16'd300, 10);
        chk("R10 unlocked clear fires", 32'(pins[0]), 0);
        run(16'd0, 16'd200, 10);
        chk("R10 locked refires", 32'(pins[0]), 1);
        run(16'd0, 16'd300, 10);
        chk("R10 unlocked gone", 32'(pins[0]), 1);

        // R4 R5 R10 full file, stall, freeing
        clear_file();
        for (int k = 0; k < 8; k++) put(mk(0, 0, 0, 1, 5), 16'(5000 + k));
        chk("R5 empty but no slot", {30'd0, hold_empty, hold_ready}, 32'b10);
        put(mk(0, 0, 0, 0, 8), 16'd6000);
        chk("R4 stalled holder", {30'd0, hold_empty, hold_ready}, 32'b00);
        put(mk(0, 0, 0, 0, 9), 16'd6000);
        run(16'd5003, 16'h0, 10);
        chk("R10 freed slot takes holder", {30'd0, hold_empty, hold_ready}, 32'b10);
        chk("R7 pin5 set", 32'(pins[5]), 1);
        @(negedge clk); swt_clr = 4'hF;
        @(negedge clk); swt_clr = 4'h0;
        run(16'd6000, 16'h0, 10);
        chk("R4 first kept second dropped", 32'(swt_flags), 32'b0001);

        // R11 clear removes locked
        put(mk(1, 0, 0, 1, 4), 16'd7000);
        chk("R11 file full before clear", 32'(hold_ready), 0);
        clear_file();
        chk("R11 slots free", 32'(hold_ready), 1);
        run(16'd7000, 16'h0, 10);
        chk("R11 locked removed", 32'(pins[4]), 0);

        // R1 latency
        put(mk(0, 0, 0, 1, 3), 16'd8000);
        begin
            int lat;
            lat = 0;
            @(negedge clk); timer1 = 16'd8000;
            while (pins[3] !== 1'b1 && lat < 20) begin
                @(negedge clk); lat++;
            end
            timer1 = 16'hFFFF;
            chk("R1 latency within pass", 32'(lat >= 1 && lat <= 8), 1);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule